// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking

This block decides which of four masters may drive a shared parallel bus. Each master raises an active-low request and receives an active-low grant. The arbiter watches the bus cycle-frame and initiator-ready strobes, both active low, to tell when the bus is idle. It moves ownership only while the bus is idle. Contending masters are served in rotating order, so none can be locked out.

When no other master is asking, the grant stays with the current owner. That owner may then start further transactions without raising its request again. One master, chosen by parameter, may not keep the bus that way: when it stops requesting, its grant is taken back. When nobody owns the bus and nobody requests, the grant can rest on a parameter-chosen default master. Every handover passes through at least one clock with no grant asserted, so two masters never drive the bus in the same cycle.

All pins are plain control signals. No data passes through the block, so it has no valid/ready stream and no back-pressure rules. Master i uses bit i of both the request and the grant vectors.

Top module: `bus_rr_arbiter`

## Requirements
- R1: While reset is asserted every grant output is high (deasserted). At no time is more than one grant output low.
- R2: The grant outputs change only at a clock edge where frame_n and irdy_n are both sampled high (bus idle). Otherwise they keep their value.
- R3: When ownership passes from one master to another, there is at least one clock in which all grant outputs are high.
- R4: With no owner and the bus idle, a grant goes to the first requesting master in rotating order. The search starts at the index after the master most recently granted in answer to a request, and wraps from 3 to 0. Directly after reset the search starts at index 0.
- R5: An owner that is not the barred master keeps its grant while no other master requests. This holds whether or not its own request is still asserted, and holds across transactions that it starts without requesting.
- R6: An owner whose request is still asserted keeps its grant, even when others request, until it has run a transaction. A transaction counts as run once frame_n has been sampled low while the owner held the grant.
- R7: An owner loses its grant at an idle edge where some other master requests and the owner has either released its request or run a transaction.
- R8: The master with index NOPARK_IDX loses its grant at the first idle edge where its own request is high, even when no other master requests.
- R9: At an idle edge with no owner and no request, the grant goes to master DEFAULT_PARK. If that value is out of range or equals NOPARK_IDX, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_AGENTS | Active-low bus requests, bit i from master i |
| frame_n | input | 1 | Active-low bus cycle-frame strobe |
| irdy_n | input | 1 | Active-low initiator-ready strobe |
| gnt_n | output | N_AGENTS | Active-low grants, bit i to master i |

## Verification
On every clock, the assertions check four things: grants are exclusive and deasserted in reset, the grant is frozen while the bus is busy, every handover has an empty cycle, and a non-barred owner stays parked while nobody else asks. The order in which competing masters are served, including the wrap from 3 to 0, can only be shown by the bench's scenarios. The same is true of whether an owner has run its transaction, the withdrawal of the barred master, and the default or empty parking choice, since each depends on history or on parameter values.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  // Action chosen for the ownership register in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DROP  = 2'd1,
    ACT_GRANT = 2'd2
  } own_act_e;
endpackage

// File: rtl/bus_arb_idle_mon.sv
module bus_arb_idle_mon (
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle,
  output logic frame_seen
);
  // Idle means neither strobe is driven. A low frame marks a started transfer.
  assign bus_idle   = frame_n & irdy_n;
  assign frame_seen = ~frame_n;
endmodule

// File: rtl/bus_arb_rr_pick.sv
module bus_arb_rr_pick #(
  parameter int N_AGENTS = 4,
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic [IW-1:0]       last_idx,
  output logic                found,
  output logic [IW-1:0]       pick_idx
);
  // Scan starting one past the last served index, wrapping to 0.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= N_AGENTS; k++) begin
      int pos;
      pos = int'(last_idx) + k;
      if (pos >= N_AGENTS) pos = pos - N_AGENTS;
      if (!found && req[pos]) begin
        found    = 1'b1;
        pick_idx = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/bus_arb_owner_ctl.sv
module bus_arb_owner_ctl
  import bus_arb_pkg::*;
#(
  parameter int N_AGENTS     = 4,
  parameter int NOPARK_IDX   = 3,
  parameter int DEFAULT_PARK = 0,
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  localparam bit DEF_OK = (DEFAULT_PARK >= 0) && (DEFAULT_PARK < N_AGENTS)
                          && (DEFAULT_PARK != NOPARK_IDX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req,
  input  logic                bus_idle,
  input  logic                frame_seen,
  input  logic                pick_found,
  input  logic [IW-1:0]       pick_idx,
  output logic [IW-1:0]       last_idx,
  output logic [N_AGENTS-1:0] grant
);
  logic          valid_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] last_q;
  logic          used_q;

  logic [N_AGENTS-1:0] own_bit;
  logic [N_AGENTS-1:0] others;
  logic                own_req;
  logic                barred;
  own_act_e            act;
  logic [IW-1:0]       nxt_idx;
  logic                from_req;

  assign own_bit = valid_q ? (N_AGENTS'(1) << owner_q) : '0;
  assign others  = req & ~own_bit;
  assign own_req = |(req & own_bit);
  assign barred  = (int'(owner_q) == NOPARK_IDX);

  always_comb begin
    act      = ACT_HOLD;
    nxt_idx  = owner_q;
    from_req = 1'b0;
    if (bus_idle) begin
      if (valid_q) begin
        if ((|others) && (used_q || !own_req)) begin
          act = ACT_DROP;
        end else if (barred && !own_req) begin
          act = ACT_DROP;
        end
      end else if (pick_found) begin
        act      = ACT_GRANT;
        nxt_idx  = pick_idx;
        from_req = 1'b1;
      end else if (DEF_OK) begin
        act     = ACT_GRANT;
        nxt_idx = IW'(DEF_OK ? DEFAULT_PARK : 0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(N_AGENTS - 1);
      used_q  <= 1'b0;
    end else begin
      case (act)
        ACT_DROP: begin
          valid_q <= 1'b0;
          used_q  <= 1'b0;
        end
        ACT_GRANT: begin
          valid_q <= 1'b1;
          owner_q <= nxt_idx;
          used_q  <= 1'b0;
          if (from_req) last_q <= nxt_idx;
        end
        default: begin
          if (valid_q && frame_seen) used_q <= 1'b1;
        end
      endcase
    end
  end

  assign last_idx = last_q;

  for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_grant
    assign grant[gi] = valid_q && (int'(owner_q) == gi);
  end
endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter #(
  parameter int N_AGENTS     = 4,
  parameter int NOPARK_IDX   = 3,
  parameter int DEFAULT_PARK = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  output logic [N_AGENTS-1:0] gnt_n
);
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [N_AGENTS-1:0] req;
  logic [N_AGENTS-1:0] grant;
  logic                bus_idle;
  logic                frame_seen;
  logic                pick_found;
  logic [IW-1:0]       pick_idx;
  logic [IW-1:0]       last_idx;

  assign req   = ~req_n;
  assign gnt_n = ~grant;

  bus_arb_idle_mon u_idle (
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .bus_idle   (bus_idle),
    .frame_seen (frame_seen)
  );

  bus_arb_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .req      (req),
    .last_idx (last_idx),
    .found    (pick_found),
    .pick_idx (pick_idx)
  );

  bus_arb_owner_ctl #(
    .N_AGENTS     (N_AGENTS),
    .NOPARK_IDX   (NOPARK_IDX),
    .DEFAULT_PARK (DEFAULT_PARK)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .bus_idle   (bus_idle),
    .frame_seen (frame_seen),
    .pick_found (pick_found),
    .pick_idx   (pick_idx),
    .last_idx   (last_idx),
    .grant      (grant)
  );
endmodule

// File: rtl/bus_rr_arbiter_chk.sv
module bus_rr_arbiter_chk #(
  parameter int N_AGENTS   = 4,
  parameter int NOPARK_IDX = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] req_n,
  input logic                frame_n,
  input logic                irdy_n,
  input logic [N_AGENTS-1:0] gnt_n
);
  logic [N_AGENTS-1:0] g;
  logic [N_AGENTS-1:0] r;
  logic [N_AGENTS-1:0] barred_mask;
  assign g = ~gnt_n;
  assign r = ~req_n;
  assign barred_mask = N_AGENTS'(1) << NOPARK_IDX;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> (&gnt_n))
    else $error("R1 grant asserted during reset");

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(g))
    else $error("R1 more than one grant");

  assert_frozen_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n || !irdy_n) |=> $stable(gnt_n))
    else $error("R2 grant moved while bus busy");

  assert_handover_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|g) |=> ((~gnt_n) == '0 || (~gnt_n) == $past(g)))
    else $error("R3 grant switched without empty cycle");

  assert_parked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|g) && ((r & ~g) == '0) && ((g & barred_mask) == '0)) |=> $stable(gnt_n))
    else $error("R5 parked owner lost grant");
endmodule

bind bus_rr_arbiter bus_rr_arbiter_chk #(
  .N_AGENTS   (N_AGENTS),
  .NOPARK_IDX (NOPARK_IDX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_n   (req_n),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .gnt_n   (gnt_n)
);

// File: tb/bus_rr_arbiter_bench.sv
module bus_rr_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [3:0] gnt_n;
  logic [3:0] gnt2_n;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_rr_arbiter #(.N_AGENTS(4), .NOPARK_IDX(3), .DEFAULT_PARK(0)) u_bus_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  bus_rr_arbiter #(.N_AGENTS(4), .NOPARK_IDX(3), .DEFAULT_PARK(7)) u_bus_rr_arbiter_nodef (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt2_n)
  );

  // Advance one clock, then settle away from the edge.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: gnt_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // One transaction by the owner: frame low one cycle, irdy low, then idle.
  task automatic run_transfer(input logic [3:0] exp, input string tag);
    frame_n = 1'b0; irdy_n = 1'b0;
    tick(); check(gnt_n, exp, tag);
    frame_n = 1'b1;
    tick(); check(gnt_n, exp, tag);
    irdy_n = 1'b1;
  endtask

  task automatic t_reset_and_default();
    #1; check(gnt_n, 4'hF, "R1 reset");
    check(gnt2_n, 4'hF, "R1 reset second instance");
    rst_n = 1'b1;
    tick(); check(gnt_n, 4'b1110, "R9 default park on 0");
    check(gnt2_n, 4'hF, "R9 out-of-range default parks nowhere");
    tick(); check(gnt2_n, 4'hF, "R9 still nowhere");
  endtask

  task automatic t_park_hold();
    tick(); tick(); check(gnt_n, 4'b1110, "R5 parked owner holds");
    run_transfer(4'b1110, "R5 transfer without request");
    tick(); check(gnt_n, 4'b1110, "R5 still parked after transfer");
  endtask

  task automatic t_handover();
    req_n = 4'b1011;
    tick(); check(gnt_n, 4'hF, "R3 empty cycle on handover");
    tick(); check(gnt_n, 4'b1011, "R4 grant to master 2");
  endtask

  task automatic t_busy_hold();
    req_n = 4'b1001;
    tick(); check(gnt_n, 4'b1011, "R6 requesting owner keeps grant");
    tick(); check(gnt_n, 4'b1011, "R6 still keeps before transfer");
    run_transfer(4'b1011, "R2 no move while busy");
    req_n = 4'b1101;
    tick(); check(gnt_n, 4'hF, "R7 owner loses grant after transfer");
    tick(); check(gnt_n, 4'b1101, "R4 grant to master 1");
  endtask

  task automatic t_rotation();
    req_n = 4'b0000;
    tick(); check(gnt_n, 4'b1101, "R6 owner 1 keeps while requesting");
    run_transfer(4'b1101, "R2 busy hold owner 1");
    req_n = 4'b0010;
    tick(); check(gnt_n, 4'hF, "R3 gap after owner 1");
    tick(); check(gnt_n, 4'b1011, "R4 after 1 comes 2");
    run_transfer(4'b1011, "R2 busy hold owner 2");
    req_n = 4'b0110;
    tick(); check(gnt_n, 4'hF, "R3 gap after owner 2");
    tick(); check(gnt_n, 4'b0111, "R4 after 2 comes 3");
    run_transfer(4'b0111, "R2 busy hold owner 3");
    req_n = 4'b1110;
    tick(); check(gnt_n, 4'hF, "R7 owner 3 released");
    tick(); check(gnt_n, 4'b1110, "R4 wrap from 3 to 0");
  endtask

  task automatic t_release_unused();
    req_n = 4'b1100;
    tick(); check(gnt_n, 4'b1110, "R6 unused owner 0 keeps");
    req_n = 4'b1101;
    tick(); check(gnt_n, 4'hF, "R7 unused owner dropped on release");
    tick(); check(gnt_n, 4'b1101, "R4 grant to master 1");
    req_n = 4'b1111;
    tick(); tick(); check(gnt_n, 4'b1101, "R5 owner 1 parked after release");
  endtask

  task automatic t_barred();
    req_n = 4'b0111;
    tick(); check(gnt_n, 4'hF, "R3 gap before master 3");
    tick(); check(gnt_n, 4'b0111, "R4 grant to master 3");
    tick(); check(gnt_n, 4'b0111, "R8 barred holds while requesting");
    req_n = 4'b1111;
    tick(); check(gnt_n, 4'hF, "R8 barred master withdrawn");
    tick(); check(gnt_n, 4'b1110, "R9 back to default 0");
  endtask

  initial begin
    t_reset_and_default();
    t_park_hold();
    t_handover();
    t_busy_hold();
    t_rotation();
    t_release_unused();
    t_barred();
    done = 1'b1;
    report();
  end

  initial begin
    #100000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule